// File: doc/BRIEF.md
# Byte ALU With Swap and Rotate

This block is the data-path calculator of a small 8-bit controller core. Each clock it takes an operation code, the working-register value, a file-register value and the current status byte. It registers one result byte and an updated status byte. The operations are:

- the three bitwise combinations of the working register with the file operand;
- inversion of either operand;
- exchange of the two halves of the file operand;
- a nine-bit rotation of the file operand through the carry flag, in either direction;
- increment and decrement of the file operand.

A one-cycle `skip_o` pulse reports when an increment or decrement lands on zero, so that the sequencer can drop the next instruction. The core decides where the result is written; this block does not.

The data width and the status-bit positions are parameters, checked at elaboration. A generate option selects whether increment and decrement also drive the carry and digit-carry flags. The default keeps those two flags untouched by counting operations.

Top module: `byte_alu`

## Requirements
- R1: While `rst_n` is low, `result_o`, `status_o` and `skip_o` are all zero.
- R2: Every output is registered: the values seen after a rising edge come from the inputs present at that edge, and they hold steady until the next edge.
- R3: Codes 0, 1 and 2 give `w_i & f_i`, `w_i | f_i` and `w_i ^ f_i`. The zero flag (status bit 2) is set exactly when the result is zero. Carry (bit 0) and digit carry (bit 1) are copied from `status_i`.
- R4: Code 3 gives `~f_i` and code 4 gives `~w_i`. The zero flag follows the result, and carry and digit carry are copied.
- R5: Code 5 gives `f_i` with its upper and lower 4-bit halves exchanged. All status bits are copied unchanged.
- R6: Code 6 rotates left through carry: the result is `{f_i[6:0], status_i[0]}` and the new carry is `f_i[7]`. Zero and digit carry are copied.
- R7: Code 7 rotates right through carry: the result is `{status_i[0], f_i[7:1]}` and the new carry is `f_i[0]`. Zero and digit carry are copied.
- R8: Code 8 gives `f_i + 1` and code 9 gives `f_i - 1`, both wrapping modulo 256. The zero flag follows the result. With the default option, carry and digit carry are copied.
- R9: `skip_o` is high after an edge only if the operation at that edge was code 8 or 9 and its result was zero.
- R10: Status bits 7 to 3 of `status_o` always equal those of `status_i` at the same edge.
- R11: Codes 10 to 15 give `f_i` unchanged, copy the whole status byte and leave `skip_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| w_i | input | 8 | Working-register operand |
| f_i | input | 8 | File-register operand |
| status_i | input | 8 | Current status byte; bit 0 is the incoming carry |
| result_o | output | 8 | Registered result byte |
| status_o | output | 8 | Registered updated status byte |
| skip_o | output | 1 | Registered zero-result pulse for increment and decrement |

## Verification
The checker takes for granted that every input is a defined value at every rising edge once reset is released. It also assumes that nothing changes the inputs between the edge that captures them and the sample of the outputs one cycle later. Its properties use the previous-cycle inputs only after one full clocked cycle out of reset. The bench drives all inputs with known values, reset included, and changes them only at falling edges. It mixes directed corner operands (results that wrap to zero, rotations with carry in set and clear, halves that are equal) with free operands over all sixteen codes.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

   typedef enum logic [3:0] {
      OP_AND   = 4'd0,
      OP_OR    = 4'd1,
      OP_XOR   = 4'd2,
      OP_NOTF  = 4'd3,
      OP_NOTW  = 4'd4,
      OP_SWAP  = 4'd5,
      OP_ROTL  = 4'd6,
      OP_ROTR  = 4'd7,
      OP_INC   = 4'd8,
      OP_DEC   = 4'd9
   } alu_op_e;

   typedef enum logic [1:0] {
      CLS_BITWISE = 2'd0,
      CLS_ROTATE  = 2'd1,
      CLS_COUNT   = 2'd2,
      CLS_PASS    = 2'd3
   } alu_cls_e;

   function automatic alu_cls_e op_class(input logic [3:0] op);
      case (op)
         OP_AND, OP_OR, OP_XOR, OP_NOTF, OP_NOTW, OP_SWAP: op_class = CLS_BITWISE;
         OP_ROTL, OP_ROTR:                                 op_class = CLS_ROTATE;
         OP_INC, OP_DEC:                                   op_class = CLS_COUNT;
         default:                                          op_class = CLS_PASS;
      endcase
   endfunction

endpackage

// File: rtl/byte_alu_bitwise.sv
module byte_alu_bitwise
   import byte_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [3:0]        op_i,
   input  logic [DATA_W-1:0] w_i,
   input  logic [DATA_W-1:0] f_i,
   output logic [DATA_W-1:0] res_o
);

   localparam int HALF_W = DATA_W / 2;

   logic [DATA_W-1:0] swapped;

   generate
      if (DATA_W % 2 == 0) begin : g_even_swap
         assign swapped = {f_i[HALF_W-1:0], f_i[DATA_W-1:HALF_W]};
      end else begin : g_no_swap
         assign swapped = f_i;
      end
   endgenerate

   always_comb begin
      case (op_i)
         OP_AND:  res_o = w_i & f_i;
         OP_OR:   res_o = w_i | f_i;
         OP_XOR:  res_o = w_i ^ f_i;
         OP_NOTF: res_o = ~f_i;
         OP_NOTW: res_o = ~w_i;
         OP_SWAP: res_o = swapped;
         default: res_o = f_i;
      endcase
   end

endmodule

// File: rtl/byte_alu_rotate.sv
module byte_alu_rotate #(
   parameter int DATA_W = 8
) (
   input  logic              right_i,
   input  logic [DATA_W-1:0] f_i,
   input  logic              cin_i,
   output logic [DATA_W-1:0] res_o,
   output logic              cout_o
);

   logic [DATA_W-1:0] left_res;
   logic [DATA_W-1:0] right_res;

   assign left_res  = {f_i[DATA_W-2:0], cin_i};
   assign right_res = {cin_i, f_i[DATA_W-1:1]};

   always_comb begin
      if (right_i) begin
         res_o  = right_res;
         cout_o = f_i[0];
      end else begin
         res_o  = left_res;
         cout_o = f_i[DATA_W-1];
      end
   end

endmodule

// File: rtl/byte_alu_count.sv
module byte_alu_count #(
   parameter int DATA_W       = 8,
   parameter bit COUNT_FLAGS  = 1'b0
) (
   input  logic              down_i,
   input  logic [DATA_W-1:0] f_i,
   input  logic              c_i,
   input  logic              dc_i,
   output logic [DATA_W-1:0] res_o,
   output logic              c_o,
   output logic              dc_o
);

   localparam int HALF_W = DATA_W / 2;
   localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

   assign res_o = down_i ? (f_i - ONE) : (f_i + ONE);

   generate
      if (COUNT_FLAGS) begin : g_flags
         always_comb begin
            if (down_i) begin
               c_o  = |f_i;
               dc_o = |f_i[HALF_W-1:0];
            end else begin
               c_o  = &f_i;
               dc_o = &f_i[HALF_W-1:0];
            end
         end
      end else begin : g_keep
         assign c_o  = c_i;
         assign dc_o = dc_i;
      end
   endgenerate

endmodule

// File: rtl/byte_alu.sv
module byte_alu
   import byte_alu_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int STAT_W      = 8,
   parameter int C_POS       = 0,
   parameter int DC_POS      = 1,
   parameter int Z_POS       = 2,
   parameter bit COUNT_FLAGS = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        op_i,
   input  logic [DATA_W-1:0] w_i,
   input  logic [DATA_W-1:0] f_i,
   input  logic [STAT_W-1:0] status_i,
   output logic [DATA_W-1:0] result_o,
   output logic [STAT_W-1:0] status_o,
   output logic              skip_o
);

   initial begin
      if (DATA_W < 4 || DATA_W % 2 != 0)
         $error("byte_alu: DATA_W must be even and at least 4");
      if (C_POS >= STAT_W || DC_POS >= STAT_W || Z_POS >= STAT_W)
         $error("byte_alu: flag position outside status byte");
      if (C_POS == DC_POS || C_POS == Z_POS || DC_POS == Z_POS)
         $error("byte_alu: flag positions must differ");
   end

   alu_cls_e          cls;
   logic [DATA_W-1:0] bw_res;
   logic [DATA_W-1:0] rot_res;
   logic              rot_c;
   logic [DATA_W-1:0] cnt_res;
   logic              cnt_c;
   logic              cnt_dc;
   logic [DATA_W-1:0] res_d;
   logic [STAT_W-1:0] stat_d;
   logic              skip_d;
   logic              upd_z;

   assign cls = op_class(op_i);

   byte_alu_bitwise #(.DATA_W(DATA_W)) u_bitwise (
      .op_i  (op_i),
      .w_i   (w_i),
      .f_i   (f_i),
      .res_o (bw_res)
   );

   byte_alu_rotate #(.DATA_W(DATA_W)) u_rotate (
      .right_i (op_i == OP_ROTR),
      .f_i     (f_i),
      .cin_i   (status_i[C_POS]),
      .res_o   (rot_res),
      .cout_o  (rot_c)
   );

   byte_alu_count #(.DATA_W(DATA_W), .COUNT_FLAGS(COUNT_FLAGS)) u_count (
      .down_i (op_i == OP_DEC),
      .f_i    (f_i),
      .c_i    (status_i[C_POS]),
      .dc_i   (status_i[DC_POS]),
      .res_o  (cnt_res),
      .c_o    (cnt_c),
      .dc_o   (cnt_dc)
   );

   always_comb begin
      res_d  = f_i;
      stat_d = status_i;
      upd_z  = 1'b0;
      skip_d = 1'b0;
      case (cls)
         CLS_BITWISE: begin
            res_d = bw_res;
            upd_z = (op_i != OP_SWAP);
         end
         CLS_ROTATE: begin
            res_d         = rot_res;
            stat_d[C_POS] = rot_c;
         end
         CLS_COUNT: begin
            res_d          = cnt_res;
            stat_d[C_POS]  = cnt_c;
            stat_d[DC_POS] = cnt_dc;
            upd_z          = 1'b1;
            skip_d         = ~|cnt_res;
         end
         default: begin
            res_d = f_i;
         end
      endcase
      if (upd_z)
         stat_d[Z_POS] = ~|res_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_o <= '0;
         status_o <= '0;
         skip_o   <= 1'b0;
      end else begin
         result_o <= res_d;
         status_o <= stat_d;
         skip_o   <= skip_d;
      end
   end

endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk #(
   parameter int DATA_W = 8,
   parameter int STAT_W = 8,
   parameter int C_POS  = 0,
   parameter int DC_POS = 1,
   parameter int Z_POS  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        op_i,
   input logic [DATA_W-1:0] f_i,
   input logic [STAT_W-1:0] status_i,
   input logic [DATA_W-1:0] result_o,
   input logic [STAT_W-1:0] status_o,
   input logic              skip_o
);

   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   always_comb begin
      if (!rst_n)
         AST_RESET_QUIET: assert (result_o == '0 && status_o == '0 && !skip_o); // R1
   end

   AST_HIGH_STATUS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> status_o[STAT_W-1:3] == $past(status_i[STAT_W-1:3])); // R10

   AST_LOGIC_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(op_i) <= 4'd2) |-> (status_o[Z_POS] == (result_o == '0))); // R3

   AST_SWAP_STATUS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(op_i) == 4'd5) |-> status_o == $past(status_i)); // R5

   AST_ROTL_CARRY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(op_i) == 4'd6) |->
         (status_o[C_POS] == $past(f_i[DATA_W-1]) && result_o[0] == $past(status_i[C_POS]))); // R6

   AST_ROTR_CARRY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(op_i) == 4'd7) |->
         (status_o[C_POS] == $past(f_i[0]) && result_o[DATA_W-1] == $past(status_i[C_POS]))); // R7

   AST_ROTATE_Z_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && ($past(op_i) == 4'd6 || $past(op_i) == 4'd7)) |->
         status_o[Z_POS] == $past(status_i[Z_POS])); // R7

   AST_SKIP_FROM_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && skip_o) |-> (($past(op_i) == 4'd8 || $past(op_i) == 4'd9) && result_o == '0)); // R9

   AST_SPARE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(op_i) >= 4'd10) |->
         (result_o == $past(f_i) && status_o == $past(status_i) && !skip_o)); // R11

endmodule

bind byte_alu byte_alu_chk #(
   .DATA_W (DATA_W),
   .STAT_W (STAT_W),
   .C_POS  (C_POS),
   .DC_POS (DC_POS),
   .Z_POS  (Z_POS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_i     (op_i),
   .f_i      (f_i),
   .status_i (status_i),
   .result_o (result_o),
   .status_o (status_o),
   .skip_o   (skip_o)
);

// File: tb/byte_alu_test.sv
module byte_alu_test;

   logic       clk;
   logic       rst_n;
   logic [3:0] op_i;
   logic [7:0] w_i;
   logic [7:0] f_i;
   logic [7:0] status_i;
   logic [7:0] result_o;
   logic [7:0] status_o;
   logic       skip_o;

   int checks;
   int failures;
   bit done;

   logic [7:0] exp_res;
   logic [7:0] exp_stat;
   logic       exp_skip;

   byte_alu uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_i     (op_i),
      .w_i      (w_i),
      .f_i      (f_i),
      .status_i (status_i),
      .result_o (result_o),
      .status_o (status_o),
      .skip_o   (skip_o)
   );

   initial clk = 1'b0;
   always #4 clk = ~clk;

   function automatic string req_tag(input int op);
      if (op <= 2)       return "R3";
      else if (op <= 4)  return "R4";
      else if (op == 5)  return "R5";
      else if (op == 6)  return "R6";
      else if (op == 7)  return "R7";
      else if (op <= 9)  return "R8";
      else               return "R11";
   endfunction

   task automatic model(input int op, input int w, input int f, input int s);
      int r;
      int c;
      int dc;
      int z;
      bit touch_z;
      c  = s & 1;
      dc = (s >> 1) & 1;
      z  = (s >> 2) & 1;
      touch_z = 1'b0;
      r = f;
      exp_skip = 1'b0;
      case (op)
         0: begin r = w & f;  touch_z = 1; end
         1: begin r = w | f;  touch_z = 1; end
         2: begin r = w ^ f;  touch_z = 1; end
         3: begin r = 255 - f; touch_z = 1; end
         4: begin r = 255 - w; touch_z = 1; end
         5: r = (f % 16) * 16 + f / 16;
         6: begin r = ((f * 2) % 256) + c; c = f / 128; end
         7: begin r = c * 128 + f / 2; c = f % 2; end
         8: begin r = (f + 1) % 256; touch_z = 1; exp_skip = (r == 0); end
         9: begin r = (f + 255) % 256; touch_z = 1; exp_skip = (r == 0); end
         default: r = f;
      endcase
      if (touch_z) z = (r == 0) ? 1 : 0;
      exp_res  = r[7:0];
      exp_stat = 8'((s & 8'hF8) | (z << 2) | (dc << 1) | c);
   endtask

   task automatic step(input int op, input int w, input int f, input int s);
      logic [7:0] prev_res;
      logic [7:0] prev_stat;
      logic       prev_skip;
      prev_res  = result_o;
      prev_stat = status_o;
      prev_skip = skip_o;
      op_i     = op[3:0];
      w_i      = w[7:0];
      f_i      = f[7:0];
      status_i = s[7:0];
      model(op, w, f, s);
      #1;
      checks++;
      if (result_o !== prev_res || status_o !== prev_stat || skip_o !== prev_skip) begin
         failures++;
         $display("FAIL R2 outputs moved before edge: got %h/%h/%b expected %h/%h/%b",
                  result_o, status_o, skip_o, prev_res, prev_stat, prev_skip);
      end
      @(negedge clk);
      checks++;
      if (result_o !== exp_res || status_o[2:0] !== exp_stat[2:0]) begin
         failures++;
         $display("FAIL %s op=%0d w=%h f=%h s=%h: got res=%h stat=%h expected res=%h stat=%h",
                  req_tag(op), op, w, f, s, result_o, status_o, exp_res, exp_stat);
      end
      checks++;
      if (status_o[7:3] !== exp_stat[7:3]) begin
         failures++;
         $display("FAIL R10 op=%0d: got upper status %h expected %h",
                  op, status_o[7:3], exp_stat[7:3]);
      end
      checks++;
      if (skip_o !== exp_skip) begin
         failures++;
         $display("FAIL R9 op=%0d f=%h: got skip=%b expected %b", op, f, skip_o, exp_skip);
      end
   endtask

   initial begin
      #1600000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      checks = 0;
      failures = 0;
      done = 1'b0;
      rst_n = 1'b0;
      op_i = 4'd0;
      w_i = 8'hA5;
      f_i = 8'h5A;
      status_i = 8'hFF;
      repeat (3) @(negedge clk);
      checks++;
      if (result_o !== 8'h00 || status_o !== 8'h00 || skip_o !== 1'b0) begin
         failures++;
         $display("FAIL R1 reset: got %h/%h/%b expected 00/00/0", result_o, status_o, skip_o);
      end
      rst_n = 1'b1;

      // R3 bitwise combinations, zero and non-zero results
      step(0, 8'hF0, 8'h0F, 8'h03);
      step(0, 8'hFF, 8'h81, 8'h04);
      step(1, 8'h00, 8'h00, 8'h00);
      step(1, 8'h12, 8'h40, 8'hFB);
      step(2, 8'h3C, 8'h3C, 8'h01);
      step(2, 8'hAA, 8'h55, 8'h06);
      // R4 complements
      step(3, 8'h00, 8'hFF, 8'h02);
      step(3, 8'h77, 8'h0F, 8'h04);
      step(4, 8'hFF, 8'h12, 8'h01);
      step(4, 8'h5A, 8'h00, 8'h00);
      // R5 swap, equal halves and distinct halves
      step(5, 8'h00, 8'hA7, 8'h05);
      step(5, 8'h00, 8'h66, 8'h02);
      // R6 / R7 rotations with carry set and clear
      step(6, 8'h00, 8'h80, 8'h00);
      step(6, 8'h00, 8'h01, 8'h01);
      step(6, 8'h00, 8'h00, 8'h04);
      step(7, 8'h00, 8'h01, 8'h00);
      step(7, 8'h00, 8'h80, 8'h01);
      step(7, 8'h00, 8'hFE, 8'h07);
      // R8 / R9 counting with wrap to zero and wrap around
      step(8, 8'h00, 8'hFF, 8'h03);
      step(8, 8'h00, 8'h0F, 8'h04);
      step(9, 8'h00, 8'h01, 8'h00);
      step(9, 8'h00, 8'h00, 8'h07);
      step(9, 8'h00, 8'h80, 8'hE0);
      // R11 spare codes
      step(10, 8'h11, 8'h22, 8'hA5);
      step(15, 8'h00, 8'h00, 8'h5A);

      for (int i = 0; i < 600; i++) begin
         step(int'($urandom_range(15)), int'($urandom_range(255)),
              int'($urandom_range(255)), int'($urandom_range(255)));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule